// File: doc/BRIEF.md
# Register-Mapped Watchdog Reset Timer

This block is a hardware watchdog that software arms and feeds through one 32-bit read/write control register on a plain memory-mapped port. The port has a valid strobe, a write flag, a byte address and 32-bit data. The control word carries a sticky arming bit and a four-bit timeout in whole seconds. Every write to that register feeds the watchdog and restarts the countdown, whatever data it carries. A prescaler divides the clock down to one-second ticks, with the clock rate given as a parameter. If the countdown runs out while the watchdog is armed, the block raises a reset request for a set number of cycles. It also records that the watchdog caused the reset.

The surrounding chip turns the reset request into a system reset and feeds it back on `sys_rst_n`. That system reset disarms the watchdog and clears its control fields. It does not clear the cause flag. The flag is kept in the power-on domain, so software can tell after restart why the system went down. A second read-only register exposes the cause flag. A third returns a fixed version number.

Top module: `wdg_timer`

## Requirements
- R1: After power-on reset the control register reads 0, the cause register reads 0 and `rst_req` is low.
- R2: The control register sits at byte address 0x14. Bit 7 is the arming bit and bits 11:8 are the timeout field. A read returns those two stored fields with every other bit zero.
- R3: Once bit 7 is set, writing 0 to it leaves the watchdog armed. Only a system reset or a power-on reset disarms it, and either one also clears the timeout field.
- R4: Any write to address 0x14 restarts the full countdown from the newly written timeout, whatever the data bits hold. This includes clearing the partial second in the prescaler.
- R5: With the watchdog armed, `rst_req` rises exactly T × CLK_HZ clock edges after the edge that took the last write to 0x14. T is the timeout field, and a field value of 0 counts as T = 1.
- R6: On expiry `rst_req` stays high for exactly RST_CYCLES consecutive cycles.
- R7: A new timeout written while the countdown runs takes effect from that write onward.
- R8: The cause register sits at address 0x18. Bit 31 is set on expiry and stays set through system resets. Only a power-on reset clears it. Its other bits read zero, and writes to it change nothing.
- R9: Address 0x1C returns FW_VERSION in bits 15:0 and zero above. Every unmapped address reads zero.
- R10: While the arming bit is clear, `rst_req` never rises, whatever the timeout field holds.
- R11: Writes to any other address, and cycles with `bus_valid` low, neither feed the watchdog nor change the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock at CLK_HZ |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything including the cause flag |
| sys_rst_n | input | 1 | System reset, active low, synchronous; clears the control register and countdown |
| bus_valid | input | 1 | Access strobe for the current cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| rst_req | output | 1 | Reset request pulse on expiry |

## Verification
The assertions assume `sys_rst_n` follows `rst_req` back from the reset sequencer. The expiry that starts a pulse therefore also disarms the block, and no second expiry can arrive while a pulse is running. They also assume the bus presents at most one access per cycle, with stable address and data within that cycle. The bench wires `sys_rst_n` to the inverse of `rst_req`, gated by its own extra system-reset control. It changes bus signals only on falling edges and issues single-cycle accesses. It never accesses the bus during a reset pulse, and every countdown it starts runs on a CLK_HZ scaled down so that expiries happen within tens of cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int REG_W     = 32;
  localparam int EN_POS    = 7;
  localparam int TMO_LSB   = 8;
  localparam int TMO_W     = 4;
  localparam int CAUSE_POS = 31;
  localparam int VER_W     = 16;

  localparam int CTRL_OFS  = 'h14;
  localparam int STAT_OFS  = 'h18;
  localparam int VER_OFS   = 'h1C;

  typedef logic [TMO_W-1:0] tmo_t;

  typedef struct packed {
    logic en;
    tmo_t secs;
  } ctrl_t;

  // Timeout field as actually counted: zero is promoted to one second.
  function automatic tmo_t eff_timeout(tmo_t field);
    return (field == '0) ? tmo_t'(1) : field;
  endfunction

  // Bits needed to count 0 .. n-1 (at least one).
  function automatic int cnt_bits(int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Control register image as seen by a read.
  function automatic logic [REG_W-1:0] ctrl_word(ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[EN_POS] = c.en;
    w[TMO_LSB +: TMO_W] = c.secs;
    return w;
  endfunction

  // Effect of a write: arming is sticky, timeout is replaced.
  function automatic ctrl_t ctrl_update(ctrl_t cur, logic [REG_W-1:0] wd);
    ctrl_t n;
    n.en   = cur.en | wd[EN_POS];
    n.secs = wd[TMO_LSB +: TMO_W];
    return n;
  endfunction

  // Cause register image as seen by a read.
  function automatic logic [REG_W-1:0] cause_word(logic flag);
    logic [REG_W-1:0] w;
    w = '0;
    w[CAUSE_POS] = flag;
    return w;
  endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int CLK_HZ = 50_000_000,
  localparam int W     = wdg_pkg::cnt_bits(CLK_HZ)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  output logic         sec_tick,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] LAST = W'(CLK_HZ - 1);

  logic at_last;
  assign at_last = (count == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !run) begin
      count <= '0;
    end else if (at_last) begin
      count <= '0;
    end else begin
      count <= count + W'(1);
    end
  end

  assign sec_tick = rst_n && run && !clear && at_last;

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  wdg_pkg::tmo_t load_val,
  input  wdg_pkg::tmo_t reload_val,
  input  logic          sec_tick,
  output logic          expire,
  output wdg_pkg::tmo_t remaining
);

  import wdg_pkg::*;

  logic last_sec;
  assign last_sec = (remaining <= tmo_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= tmo_t'(1);
    end else if (load) begin
      remaining <= load_val;
    end else if (sec_tick) begin
      if (last_sec) begin
        remaining <= reload_val;
      end else begin
        remaining <= remaining - tmo_t'(1);
      end
    end
  end

  assign expire = rst_n && !load && sec_tick && last_sec;

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int RST_CYCLES = 16,
  localparam int W         = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic active
);

  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      left <= '0;
    end else if (fire) begin
      left <= W'(RST_CYCLES);
    end else if (left != '0) begin
      left <= left - W'(1);
    end
  end

  assign active = (left != '0);

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          RST_CYCLES = 16,
  parameter int          ADDR_W     = 8,
  parameter logic [15:0] FW_VERSION = 16'h0103
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);

  import wdg_pkg::*;

  localparam int PRE_W = cnt_bits(CLK_HZ);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(VER_OFS);

  // Named internal events (also observed by the checker)
  logic             rst_ok;
  logic             kick_evt;
  logic             expire_evt;
  logic             sec_tick;
  logic             ctrl_en;
  logic             wd_flag;
  logic [PRE_W-1:0] pre_cnt;
  tmo_t             sec_left;
  ctrl_t            ctrl_q;

  assign rst_ok   = por_n && sys_rst_n;
  assign kick_evt = rst_ok && bus_valid && bus_write && (bus_addr == A_CTRL);
  assign ctrl_en  = ctrl_q.en;

  // Control register: system-reset domain
  always_ff @(posedge clk) begin
    if (!rst_ok) begin
      ctrl_q <= '0;
    end else if (kick_evt) begin
      ctrl_q <= ctrl_update(ctrl_q, bus_wdata);
    end
  end

  // Cause flag: power-on domain only
  always_ff @(posedge clk) begin
    if (!por_n) begin
      wd_flag <= 1'b0;
    end else if (expire_evt) begin
      wd_flag <= 1'b1;
    end
  end

  wdg_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
    .clk      (clk),
    .rst_n    (rst_ok),
    .run      (ctrl_en),
    .clear    (kick_evt),
    .sec_tick (sec_tick),
    .count    (pre_cnt)
  );

  wdg_countdown u_cnt (
    .clk        (clk),
    .rst_n      (rst_ok),
    .load       (kick_evt),
    .load_val   (eff_timeout(bus_wdata[TMO_LSB +: TMO_W])),
    .reload_val (eff_timeout(ctrl_q.secs)),
    .sec_tick   (sec_tick),
    .expire     (expire_evt),
    .remaining  (sec_left)
  );

  wdg_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk    (clk),
    .por_n  (por_n),
    .fire   (expire_evt),
    .active (rst_req)
  );

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = ctrl_word(ctrl_q);
        A_STAT:  bus_rdata = cause_word(wd_flag);
        A_VER:   bus_rdata = {{(REG_W-VER_W){1'b0}}, FW_VERSION};
        default: bus_rdata = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:TMO_LSB+TMO_W], bus_wdata[EN_POS-1:0]};

endmodule

// File: rtl/wdg_timer_sva.sv
module wdg_timer_sva #(
  parameter int PW         = 1,
  parameter int RST_CYCLES = 16,
  parameter int ADDR_W     = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              kick_evt,
  input logic              expire_evt,
  input logic              ctrl_en,
  input logic              wd_flag,
  input logic              rst_req,
  input logic [PW-1:0]     pre_cnt,
  input wdg_pkg::tmo_t     sec_left,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata
);

  localparam int RW = $clog2(RST_CYCLES + 1) + 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(wdg_pkg::CTRL_OFS);

  logic [RW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (!por_n)       run_len <= '0;
    else if (rst_req) run_len <= run_len + RW'(1);
    else              run_len <= '0;
  end

  p_kick_clears_prescale_r4: assert property (@(posedge clk) disable iff (!por_n)
    kick_evt |=> (pre_cnt == '0));

  p_armed_count_live_r5: assert property (@(posedge clk) disable iff (!por_n)
    ctrl_en |-> (sec_left != '0));

  p_en_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_en && sys_rst_n) |=> ctrl_en);

  p_no_expire_idle_r10: assert property (@(posedge clk) disable iff (!por_n)
    !ctrl_en |-> !expire_evt);

  p_req_follows_expire_r6: assert property (@(posedge clk) disable iff (!por_n)
    expire_evt |=> rst_req);

  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> (run_len < RW'(RST_CYCLES)));

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!por_n)
    expire_evt |=> wd_flag);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    wd_flag |=> wd_flag);

  p_ctrl_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
    (bus_valid && !bus_write && bus_addr == A_CTRL) |->
      (bus_rdata[31:12] == '0 && bus_rdata[6:0] == '0));

endmodule

bind wdg_timer wdg_timer_sva #(
  .PW(PRE_W), .RST_CYCLES(RST_CYCLES), .ADDR_W(ADDR_W)
) u_sva (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .kick_evt(kick_evt),
  .expire_evt(expire_evt), .ctrl_en(ctrl_en), .wd_flag(wd_flag),
  .rst_req(rst_req), .pre_cnt(pre_cnt), .sec_left(sec_left),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/tb_wdg_timer.sv
module tb_wdg_timer;

  localparam int          HZ  = 10;
  localparam int          RC  = 3;
  localparam int          AW  = 8;
  localparam logic [15:0] VER = 16'hA5C3;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          ext_sys_n = 1'b1;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          rst_req;
  logic          sys_rst_n;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign sys_rst_n = ext_sys_n & ~rst_req;

  wdg_timer #(.CLK_HZ(HZ), .RST_CYCLES(RC), .ADDR_W(AW), .FW_VERSION(VER)) dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  // ---------------- reference model ----------------
  int m_en = 0, m_tmo = 0, m_rem = 0, m_pulse = 0, m_flag = 0;

  function automatic int secs_of(int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    case (a)
      8'h14:   return 32'(m_en * 128 + m_tmo * 256);
      8'h18:   return m_flag ? 32'h8000_0000 : 32'h0;
      8'h1C:   return {16'h0, VER};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit sys_ok, kick, fire;
    sys_ok = ext_sys_n && (m_pulse == 0);
    kick = bus_valid && bus_write && (bus_addr == 8'h14);
    fire = 0;
    if (!por_n) begin
      m_en = 0; m_tmo = 0; m_rem = 0; m_pulse = 0; m_flag = 0;
    end else begin
      if (!sys_ok) begin
        m_en = 0; m_tmo = 0; m_rem = 0;
      end else if (kick) begin
        if (bus_wdata[7]) m_en = 1;
        m_tmo = int'(bus_wdata[11:8]);
        m_rem = secs_of(m_tmo) * HZ;
      end else if (m_en != 0) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          fire = 1;
          m_rem = secs_of(m_tmo) * HZ;
        end
      end
      if (fire) begin
        m_pulse = RC;
        m_flag = 1;
      end else if (m_pulse > 0) begin
        m_pulse = m_pulse - 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the edge
  always @(negedge clk) begin
    #2;
    if (por_n && !done) begin
      check("R6 rst_req vs model", {31'h0, rst_req}, {31'h0, m_pulse > 0});
      if (bus_valid && !bus_write) begin
        case (bus_addr)
          8'h14:   check("R2 ctrl read vs model", bus_rdata, model_read(bus_addr));
          8'h18:   check("R8 cause read vs model", bus_rdata, model_read(bus_addr));
          default: check("R9 read vs model", bus_rdata, model_read(bus_addr));
        endcase
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  // Called right after a kick write returns: 0 edges elapsed since kick.
  task automatic expect_rise(input string tag, input int t, input int used);
    repeat (t * HZ - 1 - used) @(negedge clk);
    #3 check({tag, " low before expiry"}, {31'h0, rst_req}, 32'h0);
    @(negedge clk);
    #3 check({tag, " high at expiry"}, {31'h0, rst_req}, 32'h1);
  endtask

  task automatic expect_pulse_tail();
    repeat (RC - 1) @(negedge clk);
    #3 check("R6 last pulse cycle", {31'h0, rst_req}, 32'h1);
    @(negedge clk);
    #3 check("R6 pulse ended", {31'h0, rst_req}, 32'h0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    por_n = 1;
    @(negedge clk);

    // R1 reset state, R9 version and unmapped
    rd(8'h14, d); check("R1 ctrl after POR", d, 32'h0);
    rd(8'h18, d); check("R1 cause after POR", d, 32'h0);
    check("R1 rst_req after POR", {31'h0, rst_req}, 32'h0);
    rd(8'h1C, d); check("R9 version", d, {16'h0, VER});
    rd(8'h20, d); check("R9 unmapped reads zero", d, 32'h0);

    // R2 field layout, unimplemented bits
    wr(8'h14, 32'hFFFF_F07F); rd(8'h14, d); check("R2 only fields stored", d, 32'h0);
    wr(8'h14, 32'h0000_0300); rd(8'h14, d); check("R2 timeout readback", d, 32'h300);

    // R10 disarmed never expires
    repeat (60) @(negedge clk);
    check("R10 no expiry while disarmed", {31'h0, rst_req}, 32'h0);

    // R5 basic expiry, R6 pulse, R3/R8 after reset
    wr(8'h14, 32'h0000_0280);
    expect_rise("R5 T=2", 2, 0);
    expect_pulse_tail();
    rd(8'h14, d); check("R3 system reset disarms", d, 32'h0);
    rd(8'h18, d); check("R8 cause set after expiry", d, 32'h8000_0000);

    // R3 sticky arming
    wr(8'h14, 32'h0000_0280);
    wr(8'h14, 32'h0000_0000);
    rd(8'h14, d); check("R3 arming stays set", d, 32'h80);
    wait (rst_req == 1'b1);
    @(negedge clk); expect_pulse_tail();

    // R5 zero timeout counts as one second
    wr(8'h14, 32'h0000_0080);
    expect_rise("R5 T=0 as 1", 1, 0);
    expect_pulse_tail();

    // R4 kick with arbitrary data restarts the countdown
    wr(8'h14, 32'h0000_0280);
    repeat (15) @(negedge clk);
    wr(8'h14, 32'h5A5A_F27F);
    expect_rise("R4 kick restarts", 2, 0);
    expect_pulse_tail();

    // R7 on-the-fly timeout change
    wr(8'h14, 32'h0000_0580);
    repeat (20) @(negedge clk);
    wr(8'h14, 32'h0000_0180);
    expect_rise("R7 new timeout", 1, 0);
    expect_pulse_tail();

    // R11 writes elsewhere and idle-valid cycles do not feed
    wr(8'h14, 32'h0000_0280);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h15, 32'h0000_0F80);
    @(negedge clk);
    bus_valid = 0; bus_write = 1; bus_addr = 8'h14; bus_wdata = 32'h0000_0F80;
    @(negedge clk);
    bus_write = 0; bus_wdata = '0;
    rd(8'h14, d); check("R11 ctrl unchanged", d, 32'h280);
    expect_rise("R11 no feed", 2, 8);
    expect_pulse_tail();

    // R8 cause survives an external system reset, cleared by POR
    @(negedge clk); ext_sys_n = 0;
    repeat (3) @(negedge clk); ext_sys_n = 1;
    rd(8'h18, d); check("R8 cause survives system reset", d, 32'h8000_0000);
    wr(8'h18, 32'h0); rd(8'h18, d); check("R8 cause not writable", d, 32'h8000_0000);
    @(negedge clk); por_n = 0;
    repeat (3) @(negedge clk); por_n = 1;
    rd(8'h18, d); check("R8 cause cleared by POR", d, 32'h0);

    // R5 longest timeout
    wr(8'h14, 32'h0000_0F80);
    expect_rise("R5 T=15", 15, 0);
    expect_pulse_tail();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule